// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers ten interrupt request lines from peripherals of an embedded controller. It turns each rising edge into a sticky pending bit. It then offers the CPU one request: the highest-ranked request that is pending and not blocked by its mask bit. The CPU sees this as a level number together with a single interrupt line. Software works through a small register port. Through it, software can block or unblock each source, read the pending bits, clear pending bits by writing ones, and read the level currently presented.

Most of the ranking is fixed. Levels 10, 9 and 8 rank on top, and levels 4 down to 1 rank at the bottom. Between these two groups sits a three-slot window that holds levels 7, 6 and 5. Software may reorder these three levels among themselves by writing a permutation register. An acknowledge pulse from the CPU retires the request that is being presented, and any other pending requests remain queued.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every mask bit reads 1 (all sources blocked), every pending bit reads 0, the permutation register reads the default value 0x24, `cpuIrq` is low and `irqLevel` is 0.
- R2: A 0-to-1 transition on `srcReq[i]` sets the pending bit of level i+1 at the next clock edge. A request that is simply held high does not set the bit again once it has been cleared.
- R3: A pending bit stays set until software writes 1 to that bit at address 1. Writing 0 to a bit leaves that bit unchanged.
- R4: A source whose mask bit is 1 never drives `cpuIrq` and is never shown on `irqLevel`. Its pending bit is still latched and can still be read.
- R5: `cpuIrq` is high exactly when at least one level is both pending and unmasked. `irqLevel` gives the number (1 to 10) of the winning level in the same cycle, and reads 0 when no level is both pending and unmasked.
- R6: The rank from highest to lowest is 10, 9, 8, then the three slots of the window, then 4, 3, 2, 1. The watchdog level 9 therefore outranks every level except 10.
- R7: The permutation register at address 2 holds three 2-bit slot codes. Bits [1:0] give the top slot of the window, bits [3:2] the middle slot and bits [5:4] the bottom slot. Code 0 means level 7, code 1 means level 6 and code 2 means level 5. The default value 0x24 gives the order 7, 6, 5.
- R8: A write to address 2 whose three codes are not a permutation of {0,1,2} (a repeated code, or code 3) is ignored, and the previous order is kept.
- R9: A one-cycle `ackIn` pulse clears only the pending bit of the level shown on `irqLevel` in that cycle. All other pending bits are kept. An `ackIn` pulse while `irqLevel` is 0 clears nothing.
- R10: The register map is as follows. Address 0 holds the mask, with bit i belonging to level i+1 and a 1 meaning blocked. Address 1 reads the pending bits and clears them on write-1. Address 2 holds the permutation register, zero-extended when read. Address 3 reads the current `irqLevel` and ignores writes. `regRdData` is a combinational function of `regAddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcReq | input | 10 | Request lines; bit i belongs to level i+1 |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 10 | Register write data |
| regRdData | output | 10 | Register read data |
| ackIn | input | 1 | CPU acknowledge pulse |
| cpuIrq | output | 1 | Interrupt request to the CPU |
| irqLevel | output | 4 | Number of the winning level, 0 when none |

## Verification
The hardest case to reach from the ports is a window ordering that is not the default, combined with several window levels pending at once. The order must be observed through repeated acknowledges, and an invalid permutation write must be shown to leave that reordered state untouched. The stimulus first installs a non-default order and raises levels 4 to 7 together. It then acknowledges them one at a time and checks each level as it surfaces. Next it sends two kinds of malformed permutation: one with a repeated code and one containing code 3. After these writes, the same ranking must still win. A further scenario masks the top level while a low level is also pending, and acknowledges, to show that the ack only touches the level that was presented.

// File: rtl/prio_irq_pkg.sv
`timescale 1ns/1ps
package prio_irq_pkg;
  parameter int NUM_SRC    = 10;
  parameter int SLICE_BASE = 5;
  parameter int SLICE_LEN  = 3;
  parameter int ADDR_W     = 2;
  localparam int CODE_W    = $clog2(SLICE_LEN);
  localparam int ORDER_W   = CODE_W * SLICE_LEN;
  localparam int LVL_W     = $clog2(NUM_SRC + 1);
  localparam int SLICE_TOP = SLICE_BASE + SLICE_LEN - 1;
  localparam int TOP_CNT   = NUM_SRC - SLICE_TOP;

  localparam logic [ADDR_W-1:0] ADDR_MASK  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_PEND  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ORDER = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADDR_LEVEL = ADDR_W'(3);

  typedef struct packed {
    logic maskWr;
    logic pendClr;
    logic orderWr;
    logic ackTake;
  } ctrlStrobe_t;

  function automatic logic [ORDER_W-1:0] defaultOrder();
    logic [ORDER_W-1:0] val;
    val = '0;
    for (int k = 0; k < SLICE_LEN; k++) val[k*CODE_W +: CODE_W] = CODE_W'(k);
    return val;
  endfunction

  function automatic logic isPermutation(logic [ORDER_W-1:0] val);
    logic ok;
    ok = 1'b1;
    for (int a = 0; a < SLICE_LEN; a++) begin
      if (int'(val[a*CODE_W +: CODE_W]) >= SLICE_LEN) ok = 1'b0;
      for (int b = a + 1; b < SLICE_LEN; b++)
        if (val[a*CODE_W +: CODE_W] == val[b*CODE_W +: CODE_W]) ok = 1'b0;
    end
    return ok;
  endfunction
endpackage

// File: rtl/prio_irq_ctrl_unit.sv
`timescale 1ns/1ps
module prio_irq_ctrl_unit
  import prio_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [NUM_SRC-1:0] regWrData,
  input  logic               ackIn,
  input  logic [NUM_SRC-1:0] maskReg,
  input  logic [NUM_SRC-1:0] pendReg,
  input  logic [ORDER_W-1:0] orderReg,
  input  logic [LVL_W-1:0]   winLevel,
  output ctrlStrobe_t        strb,
  output logic [NUM_SRC-1:0] regRdData
);
  logic orderOk;

  assign orderOk = isPermutation(regWrData[ORDER_W-1:0]);

  always_comb begin
    strb         = '0;
    strb.maskWr  = regWrEn && (regAddr == ADDR_MASK);
    strb.pendClr = regWrEn && (regAddr == ADDR_PEND);
    strb.orderWr = regWrEn && (regAddr == ADDR_ORDER) && orderOk;
    strb.ackTake = ackIn && (winLevel != '0);
  end

  always_comb begin
    unique case (regAddr)
      ADDR_MASK:  regRdData = maskReg;
      ADDR_PEND:  regRdData = pendReg;
      ADDR_ORDER: regRdData = NUM_SRC'(orderReg);
      default:    regRdData = NUM_SRC'(winLevel);
    endcase
  end

  // A write to the level address never raises any register strobe
  assert_level_addr_readonly_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_LEVEL) |-> !(strb.maskWr || strb.pendClr || strb.orderWr));
endmodule

// File: rtl/prio_irq_datapath.sv
`timescale 1ns/1ps
module prio_irq_datapath
  import prio_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  ctrlStrobe_t        strb,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic [LVL_W-1:0]   winLevel,
  output logic [NUM_SRC-1:0] maskReg,
  output logic [NUM_SRC-1:0] pendReg,
  output logic [ORDER_W-1:0] orderReg,
  output logic [NUM_SRC-1:0] activeVec
);
  logic [NUM_SRC-1:0] srcPrev;
  logic [NUM_SRC-1:0] reqRise;
  logic [NUM_SRC-1:0] swClear;
  logic [NUM_SRC-1:0] ackClear;

  assign reqRise = srcReq & ~srcPrev;
  assign swClear = strb.pendClr ? wrData : '0;

  genvar i;
  generate
    for (i = 0; i < NUM_SRC; i++) begin : g_ack
      assign ackClear[i] = strb.ackTake && (winLevel == LVL_W'(i + 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcPrev  <= '0;
      pendReg  <= '0;
      maskReg  <= '1;
      orderReg <= defaultOrder();
    end else begin
      srcPrev <= srcReq;
      pendReg <= (pendReg & ~swClear & ~ackClear) | reqRise;
      if (strb.maskWr)  maskReg  <= wrData;
      if (strb.orderWr) orderReg <= wrData[ORDER_W-1:0];
    end
  end

  assign activeVec = pendReg & ~maskReg;

  // The slice order register always holds a valid permutation
  assert_order_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    isPermutation(orderReg));

  generate
    for (i = 0; i < NUM_SRC; i++) begin : g_chk
      // Pending only rises after a request edge
      assert_pend_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
        $rose(pendReg[i]) |-> $past(srcReq[i] && !srcPrev[i]));
      // Pending only falls through a W1C write or an ack on that level
      assert_pend_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
        $fell(pendReg[i]) |-> $past((strb.pendClr && wrData[i]) ||
                                    (strb.ackTake && winLevel == LVL_W'(i + 1))));
      // Ack of another level leaves this pending bit alone
      assert_ack_keeps_others_R9: assert property (@(posedge clk) disable iff (!rstN)
        (strb.ackTake && winLevel != LVL_W'(i + 1) && pendReg[i] &&
         !(strb.pendClr && wrData[i])) |=> pendReg[i]);
    end
  endgenerate
endmodule

// File: rtl/prio_irq_resolver.sv
`timescale 1ns/1ps
module prio_irq_resolver
  import prio_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] activeVec,
  input  logic [ORDER_W-1:0] orderReg,
  output logic [LVL_W-1:0]   winLevel,
  output logic               irqValid
);
  logic [LVL_W-1:0] rankLevel [NUM_SRC];

  genvar r;
  generate
    for (r = 0; r < NUM_SRC; r++) begin : g_rank
      if (r >= TOP_CNT && r < TOP_CNT + SLICE_LEN) begin : g_slot
        assign rankLevel[r] = LVL_W'(SLICE_TOP) -
                              LVL_W'(orderReg[(r-TOP_CNT)*CODE_W +: CODE_W]);
      end else begin : g_fixed
        assign rankLevel[r] = LVL_W'(NUM_SRC - r);
      end
    end
  endgenerate

  always_comb begin
    logic [LVL_W-1:0] idx;
    winLevel = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      idx = rankLevel[k] - LVL_W'(1);
      if (activeVec[idx]) winLevel = rankLevel[k];
    end
  end

  assign irqValid = |activeVec;

  assert_irq_matches_level_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqValid == (winLevel != '0));
  assert_winner_active_R4: assert property (@(posedge clk) disable iff (!rstN)
    (winLevel != '0) |-> activeVec[winLevel - LVL_W'(1)]);
  assert_top_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    activeVec[NUM_SRC-1] |-> winLevel == LVL_W'(NUM_SRC));
  assert_watchdog_second_R6: assert property (@(posedge clk) disable iff (!rstN)
    (activeVec[NUM_SRC-2] && !activeVec[NUM_SRC-1]) |-> winLevel == LVL_W'(NUM_SRC-1));
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [NUM_SRC-1:0] regWrData,
  output logic [NUM_SRC-1:0] regRdData,
  input  logic               ackIn,
  output logic               cpuIrq,
  output logic [LVL_W-1:0]   irqLevel
);
  ctrlStrobe_t        strb;
  logic [NUM_SRC-1:0] maskReg;
  logic [NUM_SRC-1:0] pendReg;
  logic [ORDER_W-1:0] orderReg;
  logic [NUM_SRC-1:0] activeVec;
  logic [LVL_W-1:0]   winLevel;

  prio_irq_ctrl_unit ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .ackIn(ackIn), .maskReg(maskReg), .pendReg(pendReg),
    .orderReg(orderReg), .winLevel(winLevel), .strb(strb), .regRdData(regRdData)
  );

  prio_irq_datapath dp_i (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .strb(strb), .wrData(regWrData),
    .winLevel(winLevel), .maskReg(maskReg), .pendReg(pendReg),
    .orderReg(orderReg), .activeVec(activeVec)
  );

  prio_irq_resolver res_i (
    .clk(clk), .rstN(rstN), .activeVec(activeVec), .orderReg(orderReg),
    .winLevel(winLevel), .irqValid(cpuIrq)
  );

  assign irqLevel = winLevel;
endmodule

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] srcReq = '0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [9:0] regWrData = '0;
  logic [9:0] regRdData;
  logic       ackIn = 1'b0;
  logic       cpuIrq;
  logic [3:0] irqLevel;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  logic [9:0] expMask, expPend;
  logic [5:0] expOrder;

  always #10 clk = ~clk;

  prio_irq_ctrl dut_i (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .ackIn(ackIn),
    .cpuIrq(cpuIrq), .irqLevel(irqLevel)
  );

  function automatic int refLevel(logic [9:0] pend, logic [9:0] msk, logic [5:0] ord);
    int ranks [10];
    logic [9:0] act;
    act = pend & ~msk;
    ranks[0] = 10; ranks[1] = 9; ranks[2] = 8;
    for (int k = 0; k < 3; k++) ranks[3+k] = 7 - int'(ord[k*2 +: 2]);
    ranks[6] = 4; ranks[7] = 3; ranks[8] = 2; ranks[9] = 1;
    for (int k = 0; k < 10; k++) if (act[ranks[k]-1]) return ranks[k];
    return 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [1:0] a, logic [9:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [1:0] a, output logic [9:0] d);
    @(negedge clk); regAddr = a; #1; d = regRdData;
  endtask

  task automatic pulseReq(logic [9:0] bits);
    @(negedge clk); srcReq = srcReq | bits;
    @(negedge clk); srcReq = srcReq & ~bits;
    expPend = expPend | bits;
  endtask

  task automatic doAck();
    int lvl;
    @(negedge clk); lvl = int'(irqLevel); ackIn = 1'b1;
    @(negedge clk); ackIn = 1'b0;
    if (lvl != 0) expPend[lvl-1] = 1'b0;
  endtask

  task automatic checkOutputs(string req);
    int e;
    e = refLevel(expPend, expMask, expOrder);
    @(negedge clk);
    chk({req, " irqLevel"}, int'(irqLevel), e);
    chk({req, " cpuIrq"}, int'(cpuIrq), int'(e != 0));
  endtask

  task automatic tReset();
    logic [9:0] d;
    regRead(2'd0, d); chk("R1 mask", int'(d), 'h3FF);
    regRead(2'd1, d); chk("R1 pending", int'(d), 0);
    regRead(2'd2, d); chk("R1 order", int'(d), 'h24);
    chk("R1 cpuIrq", int'(cpuIrq), 0);
    chk("R1 irqLevel", int'(irqLevel), 0);
  endtask

  task automatic tLatchMask();
    logic [9:0] d;
    pulseReq(10'b0000000100);
    regRead(2'd1, d); chk("R2 edge latched", int'(d), 'h004);
    checkOutputs("R4 masked hidden");
    regWrite(2'd1, 10'h000);
    regRead(2'd1, d); chk("R3 zero write keeps", int'(d), 'h004);
    expMask = 10'h3FB; regWrite(2'd0, expMask);
    checkOutputs("R5 unmasked level3");
    regRead(2'd3, d); chk("R10 level readback", int'(d), 3);
    expPend = '0; regWrite(2'd1, 10'h004);
    regRead(2'd1, d); chk("R3 W1C clears", int'(d), 0);
    checkOutputs("R5 none pending");
    // held request: one edge only
    @(negedge clk); srcReq[0] = 1'b1;
    repeat (2) @(negedge clk);
    regRead(2'd1, d); chk("R2 held sets once", int'(d), 'h001);
    regWrite(2'd1, 10'h001);
    repeat (3) @(negedge clk);
    regRead(2'd1, d); chk("R2 held no re-set", int'(d), 0);
    @(negedge clk); srcReq[0] = 1'b0;
    expPend = '0;
  endtask

  task automatic tFixedOrder();
    logic [9:0] d;
    expMask = '0; regWrite(2'd0, expMask);
    pulseReq(10'b1100001001);  // levels 1,4,9,10
    checkOutputs("R6 top first");
    doAck();
    checkOutputs("R6 watchdog next");
    regRead(2'd1, d); chk("R9 ack keeps others", int'(d), int'(expPend));
    regWrite(2'd1, 10'h3FF); expPend = '0;
    pulseReq(10'h3FF);
    for (int k = 0; k < 10; k++) begin
      checkOutputs("R6 sweep");
      doAck();
      regRead(2'd1, d); chk("R9 sweep pending", int'(d), int'(expPend));
    end
    doAck();
    checkOutputs("R9 ack idle");
  endtask

  task automatic tSlice();
    logic [9:0] d;
    expOrder = 6'b01_00_10;  // 5, 7, 6
    regWrite(2'd2, 10'(expOrder));
    regRead(2'd2, d); chk("R7 order readback", int'(d), 'h12);
    pulseReq(10'b0001111000);  // levels 4..7
    for (int k = 0; k < 4; k++) begin
      checkOutputs("R7 slice ranking");
      doAck();
    end
    pulseReq(10'b0010010000);  // levels 5 and 8
    checkOutputs("R6 level8 above slice");
    regWrite(2'd1, 10'h3FF); expPend = '0;
  endtask

  task automatic tInvalid();
    logic [9:0] d;
    regWrite(2'd2, 10'b00_00_01);
    regRead(2'd2, d); chk("R8 duplicate ignored", int'(d), int'(expOrder));
    regWrite(2'd2, 10'b11_10_01);
    regRead(2'd2, d); chk("R8 code3 ignored", int'(d), int'(expOrder));
    regWrite(2'd3, 10'h3FF);
    regRead(2'd0, d); chk("R10 level addr write ignored", int'(d), int'(expMask));
    pulseReq(10'b0001100000);  // levels 6 and 7
    checkOutputs("R8 order kept");
    regWrite(2'd1, 10'h3FF); expPend = '0;
  endtask

  task automatic tMaskedAck();
    logic [9:0] d;
    pulseReq(10'b1000000010);  // levels 2 and 10
    expMask = 10'h200; regWrite(2'd0, expMask);
    checkOutputs("R4 masked top skipped");
    doAck();
    regRead(2'd1, d); chk("R9 masked top stays", int'(d), 'h200);
    checkOutputs("R4 only masked left");
  endtask

  initial begin
    expMask = 10'h3FF; expPend = '0; expOrder = 6'h24;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tLatchMask();
    tFixedOrder();
    tSlice();
    tInvalid();
    tMaskedAck();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end
endmodule